// File: doc/BRIEF.md
# Receive 40-to-66 Width Expander with Bit Slip

This block sits between a serial-to-parallel converter and a 66-bit block decoder. On every clock it accepts one 40-bit word of received line data and packs the bits into 66-bit blocks. A block leaves on the same clock domain together with a one-cycle valid strobe. Sixty-six output bits are built from forty input bits per cycle, so the strobe is high on 20 of every 33 cycles.

Word alignment is adjusted from outside through a slip request. On each rising edge of that request, the block discards the single oldest bit it has not yet emitted. Every later block then starts one line bit further into the stream. A static configuration input can invert every received bit before buffering, to correct swapped differential pairs.

Neither stream side carries a ready signal. The input side has no valid either, so a word is taken on every clock. The output side cannot be stalled: a downstream consumer must capture a block in every cycle where the strobe is high.

Top module: `rx_width_expander`

## Requirements
- R1: Bit 0 of each input word is the earliest received bit, and bit 0 of each output block is the earliest bit of that block. Successive valid blocks are consecutive, non-overlapping 66-bit slices of the received stream, with no gaps except for bits removed by slips.
- R2: With no slips after reset, `blk_valid_o` is high on exactly 20 cycles in every 33-cycle window counted from the first cycle after reset.
- R3: A slip happens only on a 0-to-1 transition of `slip_req_i` sampled at a clock edge. Holding the request high for several cycles causes exactly one slip.
- R4: Each slip removes exactly one bit: the oldest received bit not yet emitted, counting bits of the word presented in the same cycle. All later blocks are displaced by one bit position in the stream.
- R5: Two separate rising edges of `slip_req_i` displace later blocks by two bits in total.
- R6: When `invert_i` is 1, every input bit is complemented before it is buffered, so emitted blocks carry the complemented stream. When it is 0, the data passes unchanged.
- R7: A block is emitted, with `blk_valid_o` high on the clock edge that samples the input word, whenever the bits held from earlier cycles, plus the current word, minus any slip, number 66 or more. Fewer than 66 bits stay buffered afterwards.
- R8: While `rst_i` is high at a clock edge, the buffer, the fill count and the slip edge history are cleared and `blk_valid_o` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive parallel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rx_word_i | input | 40 | Received word, bit 0 earliest |
| slip_req_i | input | 1 | Slip request, acts on its rising edge |
| invert_i | input | 1 | Static polarity inversion enable |
| blk_o | output | 66 | Assembled block, bit 0 earliest |
| blk_valid_o | output | 1 | High for one cycle when `blk_o` holds a new block |

## Verification
The bench targets slips that arrive in the same cycle a block completes. A design that drops the wrong bit there, such as the newest bit or a bit of the block being emitted, shifts the data by the wrong amount and miscompares from that block onward. A slip request held high for several cycles is included, because a level-sensitive design would slip on every one of those cycles and drift further on each block. Slips right after reset, when the buffer is nearly empty, are also covered. The strobe is counted over 33-cycle windows, which catches an off-by-one in the 66-bit threshold: that error changes the 20-of-33 count or moves the strobe to a different cycle than the bit-count model predicts.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  parameter int unsigned IN_W  = 40;
  parameter int unsigned OUT_W = 66;
endpackage

// File: rtl/rxw_polarity.sv
module rxw_polarity #(
  parameter int unsigned W          = 40,
  parameter bit          INV_SUPPORT = 1'b1
) (
  input  logic [W-1:0] word_i,
  input  logic         invert_i,
  output logic [W-1:0] word_o
);
  generate
    if (INV_SUPPORT) begin : g_inv
      assign word_o = word_i ^ {W{invert_i}};
    end else begin : g_pass
      logic unused_inv;
      assign unused_inv = invert_i;
      assign word_o     = word_i;
    end
  endgenerate
endmodule

// File: rtl/rxw_slip_edge.sv
module rxw_slip_edge (
  input  logic clk_i,
  input  logic rst_i,
  input  logic req_i,
  output logic pulse_o
);
  logic prev_q;
  logic seen_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= req_i;
      seen_q <= 1'b1;
    end
  end

  assign pulse_o = req_i & ~prev_q;

  // R3: two slips never come from consecutive cycles of one request
  a_r3_one_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |=> !pulse_o);

  // R3: a request that stayed high produces no further slip
  a_r3_level_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
    (seen_q && req_i && $past(req_i)) |-> !pulse_o);
endmodule

// File: rtl/rxw_accum.sv
module rxw_accum #(
  parameter int unsigned IN_W  = 40,
  parameter int unsigned OUT_W = 66
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [IN_W-1:0]  word_i,
  input  logic             slip_i,
  output logic [OUT_W-1:0] blk_o,
  output logic             valid_o
);
  localparam int unsigned BUF_W = OUT_W + IN_W - 1;
  localparam int unsigned CNT_W = $clog2(BUF_W + 1);

  logic [BUF_W-1:0] buf_q, merged, remain;
  logic [CNT_W-1:0] fill_q, total, fill_nx;
  logic             emit;
  logic             seen_q;

  always_comb begin
    merged = buf_q | (BUF_W'(word_i) << fill_q);
    total  = fill_q + CNT_W'(IN_W);
    if (slip_i) begin
      merged = merged >> 1;
      total  = total - CNT_W'(1);
    end
    emit = (total >= CNT_W'(OUT_W));
    if (emit) begin
      remain  = merged >> OUT_W;
      fill_nx = total - CNT_W'(OUT_W);
    end else begin
      remain  = merged;
      fill_nx = total;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      buf_q   <= '0;
      fill_q  <= '0;
      valid_o <= 1'b0;
      blk_o   <= '0;
      seen_q  <= 1'b0;
    end else begin
      buf_q   <= remain;
      fill_q  <= fill_nx;
      valid_o <= emit;
      seen_q  <= 1'b1;
      if (emit) blk_o <= merged[OUT_W-1:0];
    end
  end

  // R7: after every update fewer than one block of bits stays buffered
  a_r7_fill_bound: assert property (@(posedge clk_i) disable iff (rst_i)
    fill_q < CNT_W'(OUT_W));

  // R7: bit accounting: the word adds its bits, a slip takes one, a block takes a block
  a_r7_fill_track: assert property (@(posedge clk_i) disable iff (rst_i)
    seen_q |-> (int'(fill_q) == int'($past(fill_q)) + int'(IN_W)
                - int'($past(slip_i)) - (valid_o ? int'(OUT_W) : 0)));

  // R4: bits above the fill level are always empty, so a slip removes a real bit
  a_r4_clean_top: assert property (@(posedge clk_i) disable iff (rst_i)
    (buf_q >> fill_q) == '0);
endmodule

// File: rtl/rx_width_expander.sv
module rx_width_expander
  import rxw_pkg::*;
#(
  parameter int unsigned IN_BITS  = IN_W,
  parameter int unsigned OUT_BITS = OUT_W
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic [IN_BITS-1:0]  rx_word_i,
  input  logic                slip_req_i,
  input  logic                invert_i,
  output logic [OUT_BITS-1:0] blk_o,
  output logic                blk_valid_o
);
  logic [IN_BITS-1:0] word_pol;
  logic               slip_pulse;

  rxw_polarity #(.W(IN_BITS), .INV_SUPPORT(1'b1)) u_pol (
    .word_i   (rx_word_i),
    .invert_i (invert_i),
    .word_o   (word_pol)
  );

  rxw_slip_edge u_edge (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .req_i   (slip_req_i),
    .pulse_o (slip_pulse)
  );

  rxw_accum #(.IN_W(IN_BITS), .OUT_W(OUT_BITS)) u_acc (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .word_i  (word_pol),
    .slip_i  (slip_pulse),
    .blk_o   (blk_o),
    .valid_o (blk_valid_o)
  );

  // R8: a reset edge always leaves the strobe low
  a_r8_reset_quiet: assert property (@(posedge clk_i)
    rst_i |=> !blk_valid_o);

  // R2: with no slip the strobe is never high two cycles after a low-fill pair
  a_r2_no_triple: assert property (@(posedge clk_i) disable iff (rst_i)
    (blk_valid_o && !slip_pulse) |=> !(blk_valid_o && $past(blk_valid_o, 2)) || !$past(blk_valid_o, 2) || $past(rst_i, 2) || $past(slip_pulse, 2) || $past(slip_pulse));
endmodule

// File: tb/rx_width_expander_bench.sv
`timescale 1ns/1ps
module rx_width_expander_bench;
  localparam int IW = 40;
  localparam int OW = 66;

  typedef struct packed {
    int pol;
    int s1;
    int s2;
    int hold;
    int ncyc;
    int win;
  } row_t;

  localparam row_t ROWS [7] = '{
    '{pol:0, s1:-1, s2:-1, hold:0, ncyc:99, win:1},
    '{pol:1, s1:-1, s2:-1, hold:0, ncyc:99, win:1},
    '{pol:0, s1:10, s2:-1, hold:1, ncyc:60, win:0},
    '{pol:0, s1:10, s2:14, hold:1, ncyc:60, win:0},
    '{pol:1, s1:5,  s2:30, hold:8, ncyc:80, win:0},
    '{pol:0, s1:0,  s2:-1, hold:2, ncyc:50, win:0},
    '{pol:1, s1:3,  s2:40, hold:1, ncyc:70, win:0}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic [IW-1:0] din;
  logic          slip_req;
  logic          inv;
  logic [OW-1:0] blk;
  logic          blk_v;

  int n_cmp = 0;
  int n_bad = 0;
  int fed, ptr, widx;
  bit prev_lvl;

  always #4 clk = ~clk;

  rx_width_expander u_rx_width_expander (
    .clk_i       (clk),
    .rst_i       (rst),
    .rx_word_i   (din),
    .slip_req_i  (slip_req),
    .invert_i    (inv),
    .blk_o       (blk),
    .blk_valid_o (blk_v)
  );

  function automatic bit sbit(int unsigned i);
    logic [31:0] h;
    h = i * 32'h9E37_79B1;
    h = h ^ (h >> 15);
    return h[3] ^ h[17];
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input logic [OW-1:0] act,
                       input logic [OW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; slip_req = 1'b0; din = '0;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check(blk_v == 1'b0, "R8", OW'(blk_v), '0);
    rst = 1'b0;
    fed = 0; ptr = 0; widx = 0; prev_lvl = 1'b0;
  endtask

  // one input word; outputs of that edge are checked at the following negedge
  task automatic cycle(input bit pol, input bit lvl, input string dreq, output bit v);
    logic [OW-1:0] exp_blk;
    bit            exp_v;
    bit            edge_s;
    for (int j = 0; j < IW; j++) din[j] = sbit(unsigned'(widx * IW + j));
    slip_req = lvl;
    inv      = pol;
    edge_s   = lvl && !prev_lvl;
    prev_lvl = lvl;
    widx++;
    fed += IW;
    if (edge_s) ptr++;
    exp_v = (fed - ptr) >= OW;
    exp_blk = '0;
    if (exp_v) begin
      for (int j = 0; j < OW; j++) exp_blk[j] = sbit(unsigned'(ptr + j)) ^ pol;
      ptr += OW;
    end
    @(posedge clk); @(negedge clk);
    check(blk_v == exp_v, "R7", OW'(blk_v), OW'(exp_v));
    if (exp_v) check(blk == exp_blk, dreq, blk, exp_blk);
    v = blk_v;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst = 1'b1; din = '0; slip_req = 1'b0; inv = 1'b0;
    fed = 0; ptr = 0; widx = 0; prev_lvl = 1'b0;

    foreach (ROWS[r]) begin
      row_t  rw;
      string dreq;
      int    wcnt;
      bit    v;
      rw = ROWS[r];
      inv = rw.pol[0];
      do_reset();
      if (rw.s2 >= 0 && rw.hold == 1)  dreq = "R5";
      else if (rw.hold > 1)            dreq = "R3";
      else if (rw.s1 >= 0)             dreq = "R4";
      else if (rw.pol != 0)            dreq = "R6";
      else                             dreq = "R1";
      wcnt = 0;
      for (int c = 0; c < rw.ncyc; c++) begin
        bit lvl;
        lvl = (rw.s1 >= 0 && c >= rw.s1 && c < rw.s1 + rw.hold) ||
              (rw.s2 >= 0 && c >= rw.s2 && c < rw.s2 + rw.hold);
        cycle(rw.pol[0], lvl, dreq, v);
        if (v) wcnt++;
        if (rw.win != 0 && (c % 33) == 32) begin
          check(wcnt == 20, "R2", OW'(wcnt), OW'(20));
          wcnt = 0;
        end
      end
    end

    // R8: reset mid-stream drops buffered bits and edge history
    begin
      bit v;
      do_reset();
      for (int c = 0; c < 5; c++) cycle(1'b0, 1'b1, "R8", v);
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      check(blk_v == 1'b0, "R8", OW'(blk_v), '0);
      rst = 1'b0;
      fed = 0; ptr = 0; widx = 0; prev_lvl = 1'b0;
      // request still high after reset: counts as a fresh rising edge
      for (int c = 0; c < 12; c++) cycle(1'b0, 1'b1, "R3", v);
    end

    summary();
  end
endmodule